// File: doc/BRIEF.md
# Six-Step Bridge Gate Sequencer

This block drives the six gate-enable lines of a three-phase bridge inverter. It divides each output cycle into six equal steps and picks a set of switches to turn on in each one. A programmable count of clocks per step sets the output frequency. One full output cycle lasts six times that count.

A mode input selects between two conduction patterns built from the same six-step sequence. In the long-conduction pattern each switch is on for half the cycle, and three switches conduct at once. In the short-conduction pattern each switch is on for a third of the cycle, and two switches conduct at once. In that pattern each leg also has an idle step, with neither of its switches on, before the partner switch takes over.

A per-leg dead-time counter holds both switches of a leg low for a programmable time after any turn-off. The mode and the period are sampled only at a cycle boundary. A step-index output and a once-per-cycle strobe let the surrounding logic align to the waveform.

Top module: `six_step_seq`

## Requirements
- R1: While rst_ni is low, gate_o, step_o and cyc_strobe_o are all zero. At the first rising edge that samples en_i low, all gates go low and step_o returns to 0, and they stay so while en_i is low.
- R2: gate_o[k] drives switch k+1. With mode_i=0 (long conduction), gate k is requested in step s when (s-k) mod 6 is 0, 1 or 2. Step 0 therefore enables switches 1, 5 and 6, and at most three gates are on at any time.
- R3: With mode_i=1 (short conduction), gate k is requested in step s when (s-k) mod 6 is 0 or 1. Step 0 enables switches 6 and 1, and at most two gates are on at any time.
- R4: Each step lasts exactly step_per_i clocks. step_o counts 0 to 5 and wraps to 0, and it changes only by +1 or back to 0.
- R5: The leg pairs are gate_o bits (0,3), (2,5) and (4,1). The two gates of a pair are never high together.
- R6: After a gate falls, its leg partner stays low for at least dead_i+1 clocks. When the partner's request starts at the same step boundary (mode 0), it stays low for exactly dead_i+1 clocks. A gate never rises in the clock right after its partner was high.
- R7: cyc_strobe_o is high for exactly one clock per cycle, in the first clock of step 0.
- R8: mode_i and step_per_i are sampled when the block starts running and when step_o wraps from 5 to 0. Changes made inside a cycle have no effect until that wrap.
- R9: A sampled step_per_i of zero keeps all gates low, holds step_o at 0 and suppresses the strobe. While the sampled period is zero, the inputs are re-sampled on every clock, so a nonzero value starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces all gates off |
| mode_i | input | 1 | 0 = long conduction, 1 = short conduction |
| step_per_i | input | PER_W | Clocks per step |
| dead_i | input | DT_W | Dead-time clocks added after a turn-off |
| gate_o | output | 6 | Gate enables; bit k drives switch k+1 |
| step_o | output | 3 | Current step index, 0 to 5 |
| cyc_strobe_o | output | 1 | One-clock pulse at the start of step 0 |

## Verification
Most internal faults reach gate_o within one step. A step counter that is off by one, or a pattern offset, gives a wrong gate set in the step where the fault occurs. A mis-timed wrap shows up as a wrong step length, or as a strobe missing or doubled within a single output cycle. A dead-time or leg-pairing fault shows only at a step boundary. It appears as a partner rising too early or as both gates of a leg high together, and it is seen within dead_i+1 clocks of the turn-off. A mode or period latched at the wrong time shows up one cycle later, as a cycle whose pattern or step length does not match the values that were sampled.

// File: rtl/six_step_pkg.sv
package six_step_pkg;
  localparam int NSW  = 6;
  localparam int NLEG = 3;

  typedef enum logic {
    MODE_180 = 1'b0,
    MODE_120 = 1'b1
  } cond_mode_e;

  // gate k requested when (step-k) mod 6 falls inside the conduction window
  function automatic logic [NSW-1:0] step_pattern(input logic [2:0] step, input cond_mode_e mode);
    logic [NSW-1:0] p;
    int d;
    for (int k = 0; k < NSW; k++) begin
      d    = (int'(step) + NSW - k) % NSW;
      p[k] = (d < 2) || (mode == MODE_180 && d == 2);
    end
    return p;
  endfunction

  function automatic int leg_upper(input int leg);
    return 2 * leg;
  endfunction

  function automatic int leg_lower(input int leg);
    return (2 * leg + 3) % NSW;
  endfunction
endpackage

// File: rtl/six_step_timer.sv
module six_step_timer
  import six_step_pkg::*;
#(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [PER_W-1:0] step_per_i,
  output logic             valid_o,
  output logic [2:0]       step_o,
  output cond_mode_e       mode_o,
  output logic             strobe_o
);
  localparam logic [2:0] LAST_STEP = 3'(NSW - 1);

  logic             run_q;
  logic [2:0]       step_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_q;
  cond_mode_e       mode_q;

  logic per_zero, step_end;
  assign per_zero = (per_q == '0);
  assign step_end = (cnt_q == per_q - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      step_q <= '0;
      cnt_q  <= '0;
      per_q  <= '0;
      mode_q <= MODE_180;
    end else if (!en_i) begin
      run_q  <= 1'b0;
      step_q <= '0;
      cnt_q  <= '0;
    end else if (!run_q || per_zero) begin
      // start, or idle on a zero period: sample settings every clock
      run_q  <= 1'b1;
      step_q <= '0;
      cnt_q  <= '0;
      per_q  <= step_per_i;
      mode_q <= cond_mode_e'(mode_i);
    end else if (step_end) begin
      cnt_q <= '0;
      if (step_q == LAST_STEP) begin
        step_q <= '0;
        per_q  <= step_per_i;
        mode_q <= cond_mode_e'(mode_i);
      end else begin
        step_q <= step_q + 3'd1;
      end
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assign valid_o  = run_q && !per_zero;
  assign step_o   = step_q;
  assign mode_o   = mode_q;
  assign strobe_o = valid_o && (step_q == '0) && (cnt_q == '0);
endmodule

// File: rtl/six_step_deadband.sv
module six_step_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic [1:0]      gate_o
);
  logic [1:0]      req_q;
  logic [DT_W-1:0] cnt_q;
  logic            turn_off;

  assign turn_off = |(req_q & ~req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      cnt_q <= '0;
    end else begin
      req_q <= req_i;
      if (turn_off)          cnt_q <= dead_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - DT_W'(1);
    end
  end

  // off at once on request drop; on only after a stable request and expired hold
  assign gate_o = (cnt_q == '0) ? (req_i & req_q) : 2'b00;
endmodule

// File: rtl/six_step_seq.sv
module six_step_seq
  import six_step_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [PER_W-1:0] step_per_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic [5:0]       gate_o,
  output logic [2:0]       step_o,
  output logic             cyc_strobe_o
);
  logic           seq_valid;
  logic [2:0]     seq_step;
  cond_mode_e     run_mode;
  logic [NSW-1:0] gate_req;
  logic [NSW-1:0] gate_drv;

  six_step_timer #(.PER_W(PER_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .mode_i     (mode_i),
    .step_per_i (step_per_i),
    .valid_o    (seq_valid),
    .step_o     (seq_step),
    .mode_o     (run_mode),
    .strobe_o   (cyc_strobe_o)
  );

  assign gate_req = seq_valid ? step_pattern(seq_step, run_mode) : '0;

  for (genvar l = 0; l < NLEG; l++) begin : g_leg
    localparam int UP = leg_upper(l);
    localparam int LO = leg_lower(l);
    logic [1:0] leg_gate;

    six_step_deadband #(.DT_W(DT_W)) i_dead (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  ({gate_req[LO], gate_req[UP]}),
      .dead_i (dead_i),
      .gate_o (leg_gate)
    );

    assign gate_drv[UP] = leg_gate[0];
    assign gate_drv[LO] = leg_gate[1];
  end

  assign gate_o = gate_drv;
  assign step_o = seq_step;
endmodule

// File: rtl/six_step_seq_chk.sv
module six_step_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [5:0] gate_o,
  input logic [2:0] step_o,
  input logic       cyc_strobe_o,
  input logic       mode_i
);
  AST_OFF_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (gate_o == 6'd0 && step_o == 3'd0)); // R1
  AST_MAX_ON_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gate_o) <= 3); // R2
  AST_MAX_ON_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> $countones(gate_o) <= 2); // R3
  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o <= 3'd5); // R4
  AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o != $past(step_o)) |-> (step_o == 3'd0 || step_o == $past(step_o) + 3'd1)); // R4
  AST_LEG_A_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[0] && gate_o[3])); // R5
  AST_LEG_B_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[2] && gate_o[5])); // R5
  AST_LEG_C_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[4] && gate_o[1])); // R5
  AST_GAP_LEG_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_o[0]) || $rose(gate_o[3])) |-> !$past(gate_o[0] || gate_o[3])); // R6
  AST_GAP_LEG_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_o[2]) || $rose(gate_o[5])) |-> !$past(gate_o[2] || gate_o[5])); // R6
  AST_GAP_LEG_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_o[4]) || $rose(gate_o[1])) |-> !$past(gate_o[4] || gate_o[1])); // R6
  AST_STROBE_STEP0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_strobe_o |-> step_o == 3'd0); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_strobe_o |=> !cyc_strobe_o); // R7
endmodule

bind six_step_seq six_step_seq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .gate_o       (gate_o),
  .step_o       (step_o),
  .cyc_strobe_o (cyc_strobe_o),
  .mode_i       (run_mode)
);

// File: tb/test_six_step_seq.sv
module test_six_step_seq;
  localparam int PER_W = 16;
  localparam int DT_W  = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             mode_i = 1'b0;
  logic [PER_W-1:0] step_per_i = '0;
  logic [DT_W-1:0]  dead_i = '0;
  logic [5:0]       gate_o;
  logic [2:0]       step_o;
  logic             cyc_strobe_o;

  int  n_checks = 0;
  int  n_errors = 0;
  int  leg_viol = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  six_step_seq #(.PER_W(PER_W), .DT_W(DT_W)) i_six_step_seq (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .mode_i       (mode_i),
    .step_per_i   (step_per_i),
    .dead_i       (dead_i),
    .gate_o       (gate_o),
    .step_o       (step_o),
    .cyc_strobe_o (cyc_strobe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected request set from R2 / R3
  function automatic logic [5:0] exp_pat(input int s, input bit short_mode);
    logic [5:0] p;
    for (int k = 0; k < 6; k++) begin
      int d;
      d    = (s - k + 6) % 6;
      p[k] = short_mode ? (d <= 1) : (d <= 2);
    end
    return p;
  endfunction

  // R5 monitor
  always @(negedge clk) begin
    if (rst_ni && ((gate_o[0] && gate_o[3]) || (gate_o[2] && gate_o[5]) || (gate_o[4] && gate_o[1])))
      leg_viol++;
  end

  task automatic stop_run();
    en_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_strobe();
    while (!cyc_strobe_o) @(negedge clk);
  endtask

  // checks one full cycle starting at the strobe clock; ends on the next strobe clock
  task automatic check_cycle(input bit short_mode, input int p, input bit sync);
    int strobes = 0;
    if (sync) wait_strobe();
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < p; c++) begin
        if (cyc_strobe_o) strobes++;
        if (c == 0) chk(step_o == 3'(s), "R4 step index", int'(step_o), s);
        if (c == p - 1)
          chk(gate_o == exp_pat(s, short_mode), short_mode ? "R3 pattern" : "R2 pattern",
              int'(gate_o), int'(exp_pat(s, short_mode)));
        @(negedge clk);
      end
    end
    chk(strobes == 1, "R7 one strobe per cycle", strobes, 1);
    chk(cyc_strobe_o == 1'b1, "R7 strobe at next cycle start", int'(cyc_strobe_o), 1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    en_i   = 1'b1;
    step_per_i = 16'd4;
    repeat (3) @(negedge clk);
    chk(gate_o == 6'd0 && step_o == 3'd0 && !cyc_strobe_o, "R1 reset state",
        int'({cyc_strobe_o, step_o, gate_o}), 0);
    en_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_long_mode();
    mode_i = 1'b0; step_per_i = 16'd6; dead_i = 8'd2; en_i = 1'b1;
    check_cycle(1'b0, 6, 1'b1);
    check_cycle(1'b0, 6, 1'b0);
    stop_run();
  endtask

  task automatic t_short_mode();
    mode_i = 1'b1; step_per_i = 16'd5; dead_i = 8'd1; en_i = 1'b1;
    check_cycle(1'b1, 5, 1'b1);
    stop_run();
  endtask

  task automatic t_dead(input int d);
    int lows = 0;
    logic prev;
    mode_i = 1'b0; step_per_i = 16'd10; dead_i = 8'(d); en_i = 1'b1;
    wait_strobe();
    prev = gate_o[0];
    @(negedge clk);
    while (!(prev && !gate_o[0])) begin
      prev = gate_o[0];
      @(negedge clk);
    end
    while (!gate_o[3]) begin
      lows++;
      @(negedge clk);
    end
    chk(lows == d + 1, "R6 dead gap", lows, d + 1);
    stop_run();
  endtask

  task automatic t_mode_change();
    mode_i = 1'b0; step_per_i = 16'd6; dead_i = 8'd1; en_i = 1'b1;
    wait_strobe();
    mode_i = 1'b1;
    check_cycle(1'b0, 6, 1'b0);  // R8 change ignored inside cycle
    check_cycle(1'b1, 6, 1'b0);  // R8 applied after wrap
    stop_run();
    mode_i = 1'b0;
  endtask

  task automatic t_period_change();
    mode_i = 1'b0; step_per_i = 16'd7; dead_i = 8'd1; en_i = 1'b1;
    wait_strobe();
    step_per_i = 16'd4;
    check_cycle(1'b0, 7, 1'b0);  // R8
    check_cycle(1'b0, 4, 1'b0);  // R8
    stop_run();
  endtask

  task automatic t_zero_period();
    int bad = 0;
    mode_i = 1'b0; step_per_i = '0; dead_i = 8'd0; en_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (gate_o != 6'd0 || step_o != 3'd0 || cyc_strobe_o) bad++;
    end
    chk(bad == 0, "R9 zero period idle", bad, 0);
    step_per_i = 16'd3;
    check_cycle(1'b0, 3, 1'b1);  // R9 restart
    stop_run();
  endtask

  task automatic t_disable();
    mode_i = 1'b0; step_per_i = 16'd6; dead_i = 8'd0; en_i = 1'b1;
    wait_strobe();
    repeat (9) @(negedge clk);
    chk(gate_o != 6'd0, "R1 running before disable", int'(gate_o), 1);
    en_i = 1'b0;
    @(negedge clk);
    chk(gate_o == 6'd0 && step_o == 3'd0 && !cyc_strobe_o, "R1 disable clears",
        int'({cyc_strobe_o, step_o, gate_o}), 0);
    repeat (5) @(negedge clk);
    chk(gate_o == 6'd0 && step_o == 3'd0, "R1 stays off", int'({step_o, gate_o}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_long_mode();
    t_short_mode();
    t_dead(0);
    t_dead(3);
    t_mode_change();
    t_period_change();
    t_zero_period();
    t_disable();
    chk(leg_viol == 0, "R5 leg exclusion", leg_viol, 0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule